// File: doc/BRIEF.md
# Dual-Channel Sampled Data Output Formatter

This block is the digital back end of a two-channel 8-bit sampling converter. Each channel runs on its own encode clock. It takes a raw offset-binary code from an idealized converter core every rising edge and passes it through a four-register pipeline. It then presents the code either unchanged or with its top bit inverted, which gives two's complement. One format select input serves both channels.

A two-bit operating mode input sets what each channel does. The modes are: both channels idle, channel B idle only, normal operation, and normal operation with channel B moved back by half a clock. That last mode uses a register clocked on the falling edge of the channel B clock. An idle channel drops its output enable, which stands in for a high-impedance pad. It also clears its pipeline. On leaving the idle state, a channel counts fifteen recovery edges and then refills its pipeline before it raises its data-valid flag again. Reset is synchronous and active low, and it is sampled on each channel's own clock.

Top module: `dual_adc_out_fmt`

## Requirements
- R1: A code on a raw input before rising edge n of that channel's clock appears on the channel's data output after rising edge n+3. That is four pipeline registers, counting the capturing edge.
- R2: With `fmt_twos` low, the output code equals the raw code (offset binary).
- R3: With `fmt_twos` high, the output code is the raw code with bit 7 inverted and bits 6..0 unchanged (two's complement).
- R4: With `mode_sel` = 2'b00, both channels hold output enable low, data-valid low and data at 8'h00. Their pipelines are flushed.
- R5: With `mode_sel` = 2'b01, channel B behaves as in R4 and channel A operates normally.
- R6: With `mode_sel` = 2'b10, both channels operate with no extra delay. On a shared clock, both outputs update after the same rising edge.
- R7: With `mode_sel` = 2'b11, channel A is unchanged. Channel B's data and data-valid are taken from a register loaded on the falling edge of the B clock, so they lag the R6 timing by half a cycle.
- R8: After a channel leaves standby, its data-valid stays low for 15 recovery edges plus 4 refill edges. It rises after the 19th rising edge that has standby deasserted.
- R9: While reset is low at a rising edge, that channel's pipeline and counters clear. After reset is released, data-valid rises after the 4th rising edge, and data reads 8'h00 until then (format offset binary).
- R10: Each channel advances only on its own clock. With the B clock stopped, channel A keeps producing correct data and channel B's outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Encode clock of channel A |
| clk_b | input | 1 | Encode clock of channel B |
| rst_n | input | 1 | Synchronous active-low reset, sampled on each channel clock |
| mode_sel | input | 2 | Operating mode: 00 all idle, 01 B idle, 10 normal, 11 B half-cycle aligned |
| fmt_twos | input | 1 | 1 selects two's-complement output, 0 offset binary |
| raw_a | input | 8 | Raw offset-binary core code, channel A |
| raw_b | input | 8 | Raw offset-binary core code, channel B |
| dout_a | output | 8 | Formatted data, channel A (0 while disabled) |
| oe_a | output | 1 | Output enable, channel A (0 models high impedance) |
| valid_a | output | 1 | Data-valid flag, channel A |
| dout_b | output | 8 | Formatted data, channel B (0 while disabled) |
| oe_b | output | 1 | Output enable, channel B |
| valid_b | output | 1 | Data-valid flag, channel B |

## Verification
The assertions take `mode_sel` to be quasi-static. They expect it to change only while both encode clocks are low, and they expect reset to stay stable across each half-cycle of the B clock. Under those conditions the falling-edge register always holds the last pipeline stage as seen at the next rising edge. The stimulus changes mode, format, reset and the B clock gate only at the falling edge of clock A, or while clock A is high with the reset change coming before the next falling edge. Raw codes also change only on falling edges, so every captured value is unambiguous. Stopping channel B is done by gating its clock while it is low, so no partial pulse or extra edge reaches the block.

// File: rtl/adcfmt_pkg.sv
// Shared types for the dual-channel output formatter.
// Assumes: the mode input is two bits wide; its encoding is fixed by the
// board-level strapping convention this block must honour.
package adcfmt_pkg;

    typedef enum logic [1:0] {
        MODE_ALL_OFF = 2'b00,
        MODE_B_OFF   = 2'b01,
        MODE_NORMAL  = 2'b10,
        MODE_ALIGN   = 2'b11
    } opmode_t;

endpackage

// File: rtl/adcfmt_mode_dec.sv
// Mode decoder: turns the two-bit operating mode into per-channel
// standby requests and the channel B alignment enable.
// Assumes: mode_sel is quasi-static and is changed only while clocks are low.
module adcfmt_mode_dec
    import adcfmt_pkg::*;
(
    input  logic [1:0] mode_sel,
    output logic       stby_a,
    output logic       stby_b,
    output logic       align_b
);

    opmode_t mode;

    // Reinterpret the raw pins as the mode type.
    assign mode = opmode_t'(mode_sel);

    // Decode each control from the mode value.
    always_comb begin
        stby_a  = (mode == MODE_ALL_OFF);
        stby_b  = (mode == MODE_ALL_OFF) || (mode == MODE_B_OFF);
        align_b = (mode == MODE_ALIGN);
    end

    // R4 R5: channel A never idles unless channel B idles too.
    always_comb begin
        if (!$isunknown(mode_sel)) begin
            stby_nest_chk: assert (!stby_a || stby_b);
        end
    end

endmodule

// File: rtl/adcfmt_recover.sv
// Recovery tracker for one channel: holds data-valid low for a fixed number
// of encode edges after standby ends, then until the pipeline has refilled.
// Assumes: RECOVER >= 1 and LAT >= 1; reset is synchronous on clk.
module adcfmt_recover #(
    parameter int LAT     = 4,
    parameter int RECOVER = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    output logic ready
);

    localparam int RW = $clog2(RECOVER + 1);
    localparam int FW = $clog2(LAT + 1);

    logic [RW-1:0] rec_cnt;
    logic [FW-1:0] fill_cnt;

    // Count down recovery, then count pipeline stages refilled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_cnt  <= '0;
            fill_cnt <= '0;
        end else if (standby) begin
            rec_cnt  <= RW'(RECOVER);
            fill_cnt <= '0;
        end else if (rec_cnt != '0) begin
            rec_cnt <= rec_cnt - RW'(1);
        end else if (fill_cnt != FW'(LAT)) begin
            fill_cnt <= fill_cnt + FW'(1);
        end
    end

    // Valid once every pipeline stage holds a post-recovery sample.
    assign ready = (fill_cnt == FW'(LAT));

    // R8
    rec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(standby) |-> (rec_cnt == RW'(RECOVER)));

    // R8
    rec_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_cnt <= RW'(RECOVER));

    // R8
    ready_after_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (rec_cnt == '0) && !$past(standby));

endmodule

// File: rtl/adcfmt_channel.sv
// One output channel: a LAT-deep sample pipeline, the standby flush and
// recovery, an optional falling-edge half-cycle stage, and format conversion.
// Assumes: raw is stable around rising edges of clk; align is quasi-static.
module adcfmt_channel #(
    parameter int W       = 8,
    parameter int LAT     = 4,
    parameter int RECOVER = 15,
    parameter bit HALF_EN = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         standby,
    input  logic         align,
    input  logic         fmt_twos,
    input  logic [W-1:0] raw,
    output logic [W-1:0] dout,
    output logic         oe,
    output logic         valid
);

    logic [W-1:0] pipe [LAT];
    logic         ready;
    logic [W-1:0] sel_code;
    logic         sel_valid;

    adcfmt_recover #(
        .LAT     (LAT),
        .RECOVER (RECOVER)
    ) u_recover (
        .clk     (clk),
        .rst_n   (rst_n),
        .standby (standby),
        .ready   (ready)
    );

    // Shift samples through the pipeline; flush on reset or standby.
    always_ff @(posedge clk) begin
        if (!rst_n || standby) begin
            for (int i = 0; i < LAT; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= raw;
            for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
        end
    end

    if (HALF_EN) begin : g_half
        logic [W-1:0] half_q;
        logic         half_v;

        // Retime the last stage and its valid flag onto the falling edge.
        always_ff @(negedge clk) begin
            if (!rst_n) begin
                half_q <= '0;
                half_v <= 1'b0;
            end else begin
                half_q <= pipe[LAT-1];
                half_v <= ready;
            end
        end

        // Pick the retimed copy only in alignment mode.
        assign sel_code  = align ? half_q : pipe[LAT-1];
        assign sel_valid = align ? half_v : ready;

        // R7
        half_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (half_q == pipe[LAT-1]));
    end else begin : g_plain
        logic align_unused;

        // Alignment has no meaning on a channel without the half stage.
        assign align_unused = align;
        assign sel_code     = pipe[LAT-1];
        assign sel_valid    = ready;
    end

    // Drive the pins: enable, formatted code, gated valid.
    always_comb begin
        oe    = !standby;
        valid = oe && sel_valid;
        dout  = '0;
        if (oe) dout = {sel_code[W-1] ^ fmt_twos, sel_code[W-2:0]};
    end

    // R4
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> !ready);

endmodule

// File: rtl/dual_adc_out_fmt.sv
// Top of the dual-channel output formatter: decodes the operating mode and
// drives two independent channels, channel B with the half-cycle option.
// Assumes: each clock is free-running or stopped low; mode and format are
// quasi-static; reset is synchronous to each channel clock.
module dual_adc_out_fmt
    import adcfmt_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int LATENCY     = 4,
    parameter int RECOVER_CYC = 15
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              fmt_twos,
    input  logic [CODE_W-1:0] raw_a,
    input  logic [CODE_W-1:0] raw_b,
    output logic [CODE_W-1:0] dout_a,
    output logic              oe_a,
    output logic              valid_a,
    output logic [CODE_W-1:0] dout_b,
    output logic              oe_b,
    output logic              valid_b
);

    logic stby_a;
    logic stby_b;
    logic align_b;

    adcfmt_mode_dec u_mode_dec (
        .mode_sel (mode_sel),
        .stby_a   (stby_a),
        .stby_b   (stby_b),
        .align_b  (align_b)
    );

    adcfmt_channel #(
        .W       (CODE_W),
        .LAT     (LATENCY),
        .RECOVER (RECOVER_CYC),
        .HALF_EN (1'b0)
    ) u_chan_a (
        .clk      (clk_a),
        .rst_n    (rst_n),
        .standby  (stby_a),
        .align    (1'b0),
        .fmt_twos (fmt_twos),
        .raw      (raw_a),
        .dout     (dout_a),
        .oe       (oe_a),
        .valid    (valid_a)
    );

    adcfmt_channel #(
        .W       (CODE_W),
        .LAT     (LATENCY),
        .RECOVER (RECOVER_CYC),
        .HALF_EN (1'b1)
    ) u_chan_b (
        .clk      (clk_b),
        .rst_n    (rst_n),
        .standby  (stby_b),
        .align    (align_b),
        .fmt_twos (fmt_twos),
        .raw      (raw_b),
        .dout     (dout_b),
        .oe       (oe_b),
        .valid    (valid_b)
    );

endmodule

// File: tb/dual_adc_out_fmt_bench.sv
module dual_adc_out_fmt_bench;

    localparam int CLK_P = 10;

    logic       clk_a = 1'b0;
    logic       b_gate = 1'b1;
    logic       clk_b;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b10;
    logic       fmt_twos = 1'b0;
    logic [7:0] raw_a = 8'h00;
    logic [7:0] raw_b = 8'h00;
    logic [7:0] dout_a, dout_b;
    logic       oe_a, oe_b, valid_a, valid_b;

    int checks = 0;
    int errors = 0;
    int ne_a = 0, ne_b = 0, act_a = 0, act_b = 0, thr_a = 4, thr_b = 4;
    bit vfb_prev = 1'b0;
    string phase = "R9";
    logic [7:0] hist_a [0:4095];
    logic [7:0] hist_b [0:4095];

    always #(CLK_P/2) clk_a = ~clk_a;
    assign clk_b = clk_a & b_gate;

    dual_adc_out_fmt u_dual_adc_out_fmt (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .mode_sel(mode_sel),
        .fmt_twos(fmt_twos), .raw_a(raw_a), .raw_b(raw_b),
        .dout_a(dout_a), .oe_a(oe_a), .valid_a(valid_a),
        .dout_b(dout_b), .oe_b(oe_b), .valid_b(valid_b)
    );

    function automatic logic [7:0] fmtf(input logic [7:0] v);
        return {v[7] ^ fmt_twos, v[6:0]};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", phase, tag, act, exp);
        end
    endtask

    // Compare all outputs with the model, just after a rising edge.
    task automatic check_outputs();
        bit oa, ob, va, vb, al;
        oa = (mode_sel != 2'b00);
        ob = mode_sel[1];
        al = (mode_sel == 2'b11);
        va = oa && (act_a >= thr_a);
        vb = ob && (al ? vfb_prev : (act_b >= thr_b));
        chk("oe_a", int'(oe_a), int'(oa));
        chk("oe_b", int'(oe_b), int'(ob));
        chk(thr_a == 19 ? "R8 valid_a" : "R9 valid_a", int'(valid_a), int'(va));
        chk(thr_b == 19 ? "R8 valid_b" : "R9 valid_b", int'(valid_b), int'(vb));
        if (!oa) chk("R4 dout_a", int'(dout_a), 0);
        else if (va) chk(fmt_twos ? "R1 R3 dout_a" : "R1 R2 dout_a",
                         int'(dout_a), int'(fmtf(hist_a[ne_a-3])));
        if (!ob) chk("R5 dout_b", int'(dout_b), 0);
        else if (vb) chk(al ? "R7 dout_b" : "R1 R6 dout_b", int'(dout_b),
                         int'(fmtf(hist_b[al ? ne_b-4 : ne_b-3])));
    endtask

    // Entered and left at a falling edge of clk_a.
    task automatic run(input int n);
        for (int k = 0; k < n; k++) begin
            raw_a = 8'((ne_a + 1) * 37 + 5);
            hist_a[ne_a + 1] = raw_a;
            if (b_gate) begin
                raw_b = 8'((ne_b + 1) * 91 + 200);
                hist_b[ne_b + 1] = raw_b;
            end
            @(posedge clk_a);
            ne_a++;
            if (mode_sel == 2'b00) begin act_a = 0; thr_a = 19; end
            else act_a++;
            if (b_gate) begin
                vfb_prev = (act_b >= thr_b);
                ne_b++;
                if (!mode_sel[1]) begin act_b = 0; thr_b = 19; end
                else act_b++;
            end
            #2;
            check_outputs();
            @(negedge clk_a);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        checks++;
        $display("FAIL R1 watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        hist_a[0] = 8'h00;
        hist_b[0] = 8'h00;
        repeat (3) @(posedge clk_a);
        #2;
        // R9: reset state
        chk("R9 valid_a", int'(valid_a), 0);
        chk("R9 valid_b", int'(valid_b), 0);
        chk("R9 dout_a", int'(dout_a), 0);
        chk("R9 dout_b", int'(dout_b), 0);
        rst_n = 1'b1;
        @(negedge clk_a);
        phase = "R9";       run(6);
        phase = "R1 R2 R6"; run(300);
        fmt_twos = 1'b1;
        phase = "R3";       run(300);
        fmt_twos = 1'b0;
        mode_sel = 2'b11;
        phase = "R7";       run(100);
        mode_sel = 2'b01;
        phase = "R5";       run(30);
        mode_sel = 2'b10;
        phase = "R8";       run(40);
        mode_sel = 2'b00;
        phase = "R4";       run(10);
        mode_sel = 2'b11;
        phase = "R8";       run(40);
        mode_sel = 2'b10;
        b_gate = 1'b0;
        phase = "R10";      run(20);
        b_gate = 1'b1;
        phase = "R10";      run(20);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule